// File: doc/BRIEF.md
# Speculative Result Reorder Buffer

This block is a circular queue that sits between out-of-order execution and the architectural state. Every instruction claims an entry at issue and receives the entry index as its tag. The entry records the instruction class, its destination register number, its result value and, for stores, a memory address, together with completion flags. Execution units report results out of order against that tag. The block hands results to the register file or the store path strictly in program order, one entry per cycle, from the oldest entry. Dependent instructions can read a pending result through the operand ports instead of waiting for the register file.

Speculation is undone in two ways. A mispredicted branch cuts the queue back so that the slot just after the branch becomes the next free slot, and every younger entry is dropped. A fault is recorded with the result, but it is acted on only when the faulting entry reaches the oldest position. At that point the whole queue is emptied, nothing is retired, and a redirect pulse is raised.

Top module: `robUnit`

## Requirements
- R1: After reset the queue is empty, `allocReady` is 1, `allocIdx` is 0, and `commitValid` and `redirect` are 0.
- R2: Each accepted allocation returns the next index, counting up modulo DEPTH. When DEPTH entries are live, `allocReady` is 0 and an allocation request is ignored. The slot freed by a retirement becomes allocatable on the cycle after that retirement.
- R3: Retirement follows allocation order, at most one entry per cycle. While an entry retires, `commitValid` is 1 and `commitKind`, `commitDest`, `commitValue` and `commitAddr` show that entry. Kind codes: 0 is a register write, 1 is a store, 2 is a branch.
- R4: An oldest entry that has not completed blocks retirement, even when younger entries have completed.
- R5: A store (kind 1) retires only after it has received both a completion with `cplIsAddr`=1, which carries the address, and a completion with `cplIsAddr`=0, which carries the data. Either order is accepted.
- R6: Each operand read port k returns the stored value of entry `rdIdx[k]` and raises `rdReady[k]` exactly when that entry has received its result.
- R7: When `mispValid` is 1 with branch index b, the next allocation index becomes b+1 modulo DEPTH. All entries younger than b are discarded and never retire, even if they had completed. A reused slot starts out not completed.
- R8: A completion with `cplExc`=1 marks its entry. When the marked entry is the oldest and has completed, `redirect` is 1 for one cycle and nothing retires. On the next cycle the queue is empty and `allocIdx` equals that entry's index.
- R9: `allocReady` is 0 in any cycle in which `mispValid` or `redirect` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| allocValid | input | 1 | Request for a new entry |
| allocKind | input | 2 | Class of the new entry (0 register, 1 store, 2 branch) |
| allocDest | input | DEST_W | Destination register number |
| allocReady | output | 1 | An entry can be taken this cycle |
| allocIdx | output | IDX_W | Index handed to the requester |
| cplValid | input | 1 | Completion report |
| cplIdx | input | IDX_W | Entry being completed |
| cplValue | input | DATA_W | Result, store data, or store address |
| cplIsAddr | input | 1 | For a store, the value is its address |
| cplExc | input | 1 | The instruction faulted |
| mispValid | input | 1 | A branch was mispredicted |
| mispIdx | input | IDX_W | Index of that branch |
| rdIdx | input | NUM_RD*IDX_W | Operand read indices, port k at bits k*IDX_W |
| rdValue | output | NUM_RD*DATA_W | Operand read values |
| rdReady | output | NUM_RD | Operand value present, one bit per port |
| commitValid | output | 1 | Oldest entry retires this cycle |
| commitKind | output | 2 | Class of the retiring entry |
| commitDest | output | DEST_W | Destination of the retiring entry |
| commitValue | output | DATA_W | Result or store data |
| commitAddr | output | DATA_W | Store address |
| redirect | output | 1 | Fault taken, queue emptied |

## Verification
Results are reported in order, in reverse order, and with the oldest entry held back. A reverse-order run that retires nothing until the oldest entry completes is what separates in-order retirement from a queue that retires whatever is ready. Stores get their two halves in both orders, which shows whether the address or the data alone is enough to retire one. A cut-back after completed younger entries, followed by a reuse of a cut slot, shows whether stale completion flags survive. A fault behind a good entry shows that the fault waits for the oldest position and then empties the queue.

// File: rtl/robPkg.sv
package robPkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } robKindE;

  // strobes issued by the control half toward the storage half
  typedef struct packed {
    logic allocEn;
    logic cplEn;
  } robStrobeS;
endpackage

// File: rtl/robData.sv
module robData
  import robPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  robStrobeS                strobe,
  input  logic [IDX_W-1:0]         allocSlot,
  input  logic [1:0]               allocKind,
  input  logic [DEST_W-1:0]        allocDest,
  input  logic [IDX_W-1:0]         cplIdx,
  input  logic [DATA_W-1:0]        cplValue,
  input  logic                     cplIsAddr,
  input  logic                     cplExc,
  input  logic [IDX_W-1:0]         headSlot,
  output logic [1:0]               headKind,
  output logic [DEST_W-1:0]        headDest,
  output logic [DATA_W-1:0]        headValue,
  output logic [DATA_W-1:0]        headAddr,
  output logic                     headReady,
  output logic                     headExc,
  input  logic [NUM_RD*IDX_W-1:0]  rdIdx,
  output logic [NUM_RD*DATA_W-1:0] rdValue,
  output logic [NUM_RD-1:0]        rdReady
);
  logic [1:0]        kindQ  [DEPTH];
  logic [DEST_W-1:0] destQ  [DEPTH];
  logic [DATA_W-1:0] valueQ [DEPTH];
  logic [DATA_W-1:0] addrQ  [DEPTH];
  logic [DEPTH-1:0]  dataOk, addrOk, excOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOk <= '0;
      addrOk <= '0;
      excOk  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.allocEn && allocSlot == IDX_W'(i)) begin
          dataOk[i] <= 1'b0;
          addrOk[i] <= 1'b0;
          excOk[i]  <= 1'b0;
        end else if (strobe.cplEn && cplIdx == IDX_W'(i)) begin
          if (cplIsAddr && kindQ[i] == KIND_STORE) addrOk[i] <= 1'b1;
          else dataOk[i] <= 1'b1;
          if (cplExc) excOk[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.allocEn && allocSlot == IDX_W'(i)) begin
        kindQ[i] <= allocKind;
        destQ[i] <= allocDest;
      end
      if (strobe.cplEn && cplIdx == IDX_W'(i)) begin
        if (cplIsAddr) addrQ[i] <= cplValue;
        else valueQ[i] <= cplValue;
      end
    end
  end

  always_comb begin
    headKind  = kindQ[headSlot];
    headDest  = destQ[headSlot];
    headValue = valueQ[headSlot];
    headAddr  = addrQ[headSlot];
    headExc   = excOk[headSlot];
    headReady = dataOk[headSlot] &&
                (kindQ[headSlot] != KIND_STORE || addrOk[headSlot]);
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    logic [IDX_W-1:0] sel;
    assign sel = rdIdx[k*IDX_W +: IDX_W];
    assign rdValue[k*DATA_W +: DATA_W] = valueQ[sel];
    assign rdReady[k] = dataOk[sel];
  end
endmodule

// File: rtl/robCtrl.sv
module robCtrl
  import robPkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             allocValid,
  input  logic             cplValid,
  input  logic             mispValid,
  input  logic [IDX_W-1:0] mispIdx,
  input  logic             headReady,
  input  logic             headExc,
  output robStrobeS        strobe,
  output logic [IDX_W-1:0] allocSlot,
  output logic [IDX_W-1:0] headSlot,
  output logic             allocReady,
  output logic             commitFire,
  output logic             flushExc
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr, cutTail;
  logic [IDX_W-1:0] mispDist;
  logic isEmpty, isFull, headDone, allocFire;

  assign isEmpty = headPtr == tailPtr;
  assign isFull  = (headPtr[IDX_W] != tailPtr[IDX_W]) &&
                   (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]);

  assign headDone   = !isEmpty && headReady;
  assign flushExc   = headDone && headExc;
  assign commitFire = headDone && !headExc;
  assign allocReady = !isFull && !mispValid && !flushExc;
  assign allocFire  = allocValid && allocReady;

  // distance of the branch from the oldest entry, then one past it
  assign mispDist = mispIdx - headPtr[IDX_W-1:0];
  assign cutTail  = headPtr + {1'b0, mispDist} + PTR_W'(1);

  assign allocSlot = tailPtr[IDX_W-1:0];
  assign headSlot  = headPtr[IDX_W-1:0];

  always_comb begin
    strobe.allocEn = allocFire;
    strobe.cplEn   = cplValid && !flushExc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flushExc) begin
      tailPtr <= headPtr;
    end else begin
      if (commitFire) headPtr <= headPtr + PTR_W'(1);
      if (mispValid) tailPtr <= cutTail;
      else if (allocFire) tailPtr <= tailPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/robUnit.sv
module robUnit
  import robPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     allocValid,
  input  logic [1:0]               allocKind,
  input  logic [DEST_W-1:0]        allocDest,
  output logic                     allocReady,
  output logic [IDX_W-1:0]         allocIdx,
  input  logic                     cplValid,
  input  logic [IDX_W-1:0]         cplIdx,
  input  logic [DATA_W-1:0]        cplValue,
  input  logic                     cplIsAddr,
  input  logic                     cplExc,
  input  logic                     mispValid,
  input  logic [IDX_W-1:0]         mispIdx,
  input  logic [NUM_RD*IDX_W-1:0]  rdIdx,
  output logic [NUM_RD*DATA_W-1:0] rdValue,
  output logic [NUM_RD-1:0]        rdReady,
  output logic                     commitValid,
  output logic [1:0]               commitKind,
  output logic [DEST_W-1:0]        commitDest,
  output logic [DATA_W-1:0]        commitValue,
  output logic [DATA_W-1:0]        commitAddr,
  output logic                     redirect
);
  robStrobeS        strobe;
  logic [IDX_W-1:0] headSlot;
  logic             headReady, headExc;

  robCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .allocValid(allocValid), .cplValid(cplValid),
    .mispValid(mispValid), .mispIdx(mispIdx),
    .headReady(headReady), .headExc(headExc),
    .strobe(strobe), .allocSlot(allocIdx), .headSlot(headSlot),
    .allocReady(allocReady), .commitFire(commitValid), .flushExc(redirect)
  );

  robData #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .DEST_W(DEST_W),
    .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .allocSlot(allocIdx), .allocKind(allocKind), .allocDest(allocDest),
    .cplIdx(cplIdx), .cplValue(cplValue), .cplIsAddr(cplIsAddr), .cplExc(cplExc),
    .headSlot(headSlot), .headKind(commitKind), .headDest(commitDest),
    .headValue(commitValue), .headAddr(commitAddr),
    .headReady(headReady), .headExc(headExc),
    .rdIdx(rdIdx), .rdValue(rdValue), .rdReady(rdReady)
  );
endmodule

// File: rtl/robChecker.sv
module robChecker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             allocValid,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocIdx,
  input logic             mispValid,
  input logic [IDX_W-1:0] mispIdx,
  input logic             commitValid,
  input logic             redirect
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (allocIdx == '0 && !commitValid && !redirect));

  // R2
  alloc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (allocValid && allocReady) |=> allocIdx == IDX_W'($past(allocIdx) + 1'b1));

  // R7
  misp_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (mispValid && !redirect) |=> allocIdx == IDX_W'($past(mispIdx) + 1'b1));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!commitValid && !redirect));
endmodule

bind robUnit robChecker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .allocValid(allocValid), .allocReady(allocReady),
  .allocIdx(allocIdx), .mispValid(mispValid), .mispIdx(mispIdx),
  .commitValid(commitValid), .redirect(redirect)
);

// File: tb/robUnit_bench.sv
module robUnit_bench;
  localparam int DEPTH = 8, DEST_W = 5, DATA_W = 32, NUM_RD = 2, IDX_W = 3;

  logic clk = 0, rst = 1;
  logic allocValid = 0, cplValid = 0, cplIsAddr = 0, cplExc = 0, mispValid = 0;
  logic [1:0] allocKind = 0;
  logic [DEST_W-1:0] allocDest = 0;
  logic [IDX_W-1:0] cplIdx = 0, mispIdx = 0;
  logic [DATA_W-1:0] cplValue = 0;
  logic [NUM_RD*IDX_W-1:0] rdIdx = 0;
  logic allocReady, commitValid, redirect;
  logic [IDX_W-1:0] allocIdx;
  logic [NUM_RD*DATA_W-1:0] rdValue;
  logic [NUM_RD-1:0] rdReady;
  logic [1:0] commitKind;
  logic [DEST_W-1:0] commitDest;
  logic [DATA_W-1:0] commitValue, commitAddr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  robUnit #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_robUnit (
    .clk(clk), .rst(rst), .allocValid(allocValid), .allocKind(allocKind),
    .allocDest(allocDest), .allocReady(allocReady), .allocIdx(allocIdx),
    .cplValid(cplValid), .cplIdx(cplIdx), .cplValue(cplValue),
    .cplIsAddr(cplIsAddr), .cplExc(cplExc), .mispValid(mispValid),
    .mispIdx(mispIdx), .rdIdx(rdIdx), .rdValue(rdValue), .rdReady(rdReady),
    .commitValid(commitValid), .commitKind(commitKind), .commitDest(commitDest),
    .commitValue(commitValue), .commitAddr(commitAddr), .redirect(redirect)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic doReset;
    allocValid = 0; cplValid = 0; mispValid = 0; cplExc = 0; cplIsAddr = 0;
    rst = 1; tick; tick; rst = 0; #1;
  endtask

  task automatic allocOne(logic [1:0] kind, logic [DEST_W-1:0] dest, logic [IDX_W-1:0] expIdx);
    allocValid = 1; allocKind = kind; allocDest = dest; #1;
    chk("R2 allocReady", allocReady, 1);
    chk("R2 allocIdx", allocIdx, expIdx);
    tick; allocValid = 0; #1;
  endtask

  task automatic complete(logic [IDX_W-1:0] idx, logic [DATA_W-1:0] val, logic isAddr, logic exc);
    cplValid = 1; cplIdx = idx; cplValue = val; cplIsAddr = isAddr; cplExc = exc;
    tick; cplValid = 0; cplExc = 0; cplIsAddr = 0; #1;
  endtask

  task automatic expCommit(string req, logic [1:0] kind, logic [DEST_W-1:0] dest, logic [DATA_W-1:0] val);
    chk({req, " commitValid"}, commitValid, 1);
    chk({req, " commitKind"}, commitKind, kind);
    chk({req, " commitDest"}, commitDest, dest);
    chk({req, " commitValue"}, commitValue, val);
  endtask

  task automatic testReset;
    doReset;
    chk("R1 allocReady", allocReady, 1);
    chk("R1 allocIdx", allocIdx, 0);
    chk("R1 commitValid", commitValid, 0);
    chk("R1 redirect", redirect, 0);
  endtask

  task automatic testOrder;
    doReset;
    allocOne(2'd0, 5'd1, 3'd0);
    allocOne(2'd0, 5'd2, 3'd1);
    allocOne(2'd0, 5'd3, 3'd2);
    complete(3'd2, 32'h33, 0, 0);
    chk("R4 younger ready, no commit", commitValid, 0);
    rdIdx = {3'd1, 3'd2}; #1;
    chk("R6 port0 value", rdValue[31:0], 32'h33);
    chk("R6 port0 ready", rdReady[0], 1);
    chk("R6 port1 not ready", rdReady[1], 0);
    complete(3'd1, 32'h22, 0, 0);
    chk("R4 head pending", commitValid, 0);
    chk("R6 port1 value", rdValue[63:32], 32'h22);
    complete(3'd0, 32'h11, 0, 0);
    expCommit("R3 first", 2'd0, 5'd1, 32'h11);
    tick; expCommit("R3 second", 2'd0, 5'd2, 32'h22);
    tick; expCommit("R3 third", 2'd0, 5'd3, 32'h33);
    tick;
    chk("R3 drained", commitValid, 0);
    chk("R2 next idx", allocIdx, 3);
  endtask

  task automatic testFull;
    doReset;
    for (int i = 0; i < DEPTH; i++) allocOne(2'd0, DEST_W'(i), IDX_W'(i));
    chk("R2 full", allocReady, 0);
    allocValid = 1; tick; allocValid = 0; #1;
    chk("R2 request ignored when full", allocIdx, 0);
    complete(3'd0, 32'h5, 0, 0);
    expCommit("R3 full head", 2'd0, 5'd0, 32'h5);
    chk("R2 still full in retire cycle", allocReady, 0);
    tick;
    chk("R2 slot freed", allocReady, 1);
    allocOne(2'd0, 5'd9, 3'd0);
  endtask

  task automatic testStore;
    doReset;
    allocOne(2'd1, 5'd0, 3'd0);
    complete(3'd0, 32'hD0, 0, 0);
    chk("R5 data only", commitValid, 0);
    complete(3'd0, 32'hA0, 1, 0);
    expCommit("R5 store", 2'd1, 5'd0, 32'hD0);
    chk("R5 store addr", commitAddr, 32'hA0);
    tick;
    allocOne(2'd1, 5'd0, 3'd1);
    complete(3'd1, 32'hA1, 1, 0);
    chk("R5 addr only", commitValid, 0);
    complete(3'd1, 32'hD1, 0, 0);
    expCommit("R5 store2", 2'd1, 5'd0, 32'hD1);
    chk("R5 store2 addr", commitAddr, 32'hA1);
  endtask

  task automatic testMisp;
    doReset;
    allocOne(2'd0, 5'd7, 3'd0);
    allocOne(2'd2, 5'd0, 3'd1);
    allocOne(2'd0, 5'd8, 3'd2);
    allocOne(2'd0, 5'd9, 3'd3);
    complete(3'd2, 32'h2, 0, 0);
    complete(3'd3, 32'h3, 0, 0);
    mispValid = 1; mispIdx = 3'd1; allocValid = 1; #1;
    chk("R9 no alloc on mispredict", allocReady, 0);
    tick; mispValid = 0; allocValid = 0; #1;
    chk("R7 tail after branch", allocIdx, 2);
    complete(3'd0, 32'h70, 0, 0);
    expCommit("R7 older survives", 2'd0, 5'd7, 32'h70);
    tick;
    complete(3'd1, 32'h0, 0, 0);
    chk("R7 branch retires kind", commitKind, 2'd2);
    chk("R7 branch retires", commitValid, 1);
    tick;
    chk("R7 younger discarded", commitValid, 0);
    allocOne(2'd0, 5'd10, 3'd2);
    chk("R7 reused slot not ready", commitValid, 0);
  endtask

  task automatic testExc;
    doReset;
    allocOne(2'd0, 5'd4, 3'd0);
    allocOne(2'd0, 5'd5, 3'd1);
    allocOne(2'd0, 5'd6, 3'd2);
    complete(3'd2, 32'h66, 0, 0);
    complete(3'd1, 32'h55, 0, 1);
    chk("R8 fault waits for head", redirect, 0);
    complete(3'd0, 32'h44, 0, 0);
    expCommit("R8 older retires", 2'd0, 5'd4, 32'h44);
    chk("R8 no redirect yet", redirect, 0);
    tick;
    chk("R8 redirect", redirect, 1);
    chk("R8 no retire on fault", commitValid, 0);
    chk("R9 no alloc on redirect", allocReady, 0);
    tick;
    chk("R8 redirect one cycle", redirect, 0);
    chk("R8 emptied", commitValid, 0);
    chk("R8 alloc idx at fault", allocIdx, 1);
    chk("R8 alloc open", allocReady, 1);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    testReset;
    testOrder;
    testFull;
    testStore;
    testMisp;
    testExc;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule